// File: doc/BRIEF.md
# Fixed-Point Width Converter with Overflow Policy

This block takes a fixed-point sample of one bit width and produces it at another width. The data is read as two's-complement or as plain binary, and this choice is made by a parameter at elaboration. A wider or equal output carries the value over unchanged. A narrower output can lose information, so a parameter picks one of three policies:
- **Wrap:** drop the upper bits.
- **Clip:** clamp to the extremes of the output range.
- **Balanced clip:** clamp to a range that is symmetric about zero. The most negative output code is never produced, which keeps a signal path free of DC bias.

An overflow flag comes out with every sample. A valid strobe travels alongside the data. Register stages can be placed before the conversion, after it, or both.

Top module: `rsz_width_conv`

## Requirements
- R1: When OUT_W >= IN_W, the output holds the same numeric value as the input. Signed data is sign-extended, unsigned data is zero-extended, and out_ovf is 0.
- R2: In wrap mode (MODE = RSZ_WRAP, encoding 0) with OUT_W < IN_W, out_data equals in_data[OUT_W-1:0]. This holds for both signed and unsigned data.
- R3: For unsigned data with OUT_W < IN_W, in clip mode (encoding 1) or balanced mode (encoding 2), an input above 2^OUT_W-1 produces 2^OUT_W-1. Any other input produces its low OUT_W bits.
- R4: For signed data in clip mode with OUT_W < IN_W, an input below -2^(OUT_W-1) produces -2^(OUT_W-1). An input above 2^(OUT_W-1)-1 produces 2^(OUT_W-1)-1. An in-range input passes unchanged.
- R5: For signed data in balanced mode (encoding 2) with OUT_W < IN_W:
  - Out-of-range inputs produce -(2^(OUT_W-1)-1) or +(2^(OUT_W-1)-1).
  - An input of exactly -2^(OUT_W-1) produces -(2^(OUT_W-1)-1).
  - The code -2^(OUT_W-1) never appears at the output.
- R6: out_ovf is 1 in the same cycle as its sample in two cases: the input value does not fit in OUT_W bits (in every mode, wrap included), or balanced mode replaced the most negative code.
- R7: out_data, out_ovf and out_vld follow in_data and in_vld after PIPE_IN + PIPE_OUT clock cycles.
- R8: While rst_n is low, out_data, out_ovf and out_vld are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | IN_W | Input sample |
| in_vld | input | 1 | Input sample qualifier |
| out_data | output | OUT_W | Converted sample |
| out_ovf | output | 1 | Overflow flag for out_data |
| out_vld | output | 1 | in_vld delayed by the pipeline |

## Verification
The bound checker holds four properties on every cycle:
- R8: the reset state.
- R1: no overflow flag on widening configurations.
- R5: the most negative code never appears in balanced mode.
- R3 and R4: every flagged sample in the clipping modes sits at the right extreme.

Only the bench's scenarios can show the rest. These are the exact converted value of each code (R2 to R5), that the flag matches range membership for each input (R6), and the alignment of data and valid across a deeper pipeline (R7). The bench covers them by sweeping every input code through widening, equal and narrowing instances in each mode, then adding random samples with gaps in valid.

// File: rtl/rsz_pkg.sv
package rsz_pkg;
   typedef enum logic [1:0] {
      RSZ_WRAP     = 2'd0,
      RSZ_CLIP     = 2'd1,
      RSZ_CLIP_SYM = 2'd2
   } rsz_mode_e;
endpackage

// File: rtl/rsz_pipe.sv
module rsz_pipe #(
   parameter int W     = 8,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (DEPTH < 0) begin : g_bad
      $error("rsz_pipe: DEPTH must be >= 0");
   end
   if (DEPTH == 0) begin : g_wire
      assign q = d;
   end else begin : g_regs
      logic [W-1:0] stage [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
         end else begin
            stage[0] <= d;
            for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
         end
      end
      assign q = stage[DEPTH-1];
   end
endmodule

// File: rtl/rsz_narrow.sv
module rsz_narrow
   import rsz_pkg::*;
#(
   parameter int        IN_W        = 5,
   parameter int        OUT_W       = 3,
   parameter bit        SIGNED_DATA = 1'b1,
   parameter rsz_mode_e MODE        = RSZ_CLIP_SYM
) (
   input  logic [IN_W-1:0]  din,
   output logic [OUT_W-1:0] dout,
   output logic             ovf
);
   if (OUT_W >= IN_W) begin : g_extend
      if (SIGNED_DATA) begin : g_sext
         logic signed [OUT_W-1:0] ext;
         assign ext  = $signed(din);
         assign dout = ext;
      end else begin : g_zext
         assign dout = OUT_W'(din);
      end
      assign ovf = 1'b0;
   end else begin : g_reduce
      localparam logic [OUT_W-1:0] SMIN    = {1'b1, {(OUT_W-1){1'b0}}};
      localparam logic [OUT_W-1:0] SMAX    = ~SMIN;
      localparam logic [OUT_W-1:0] SYM_MIN = SMIN + OUT_W'(1);
      localparam logic [OUT_W-1:0] UMAX    = '1;

      logic [OUT_W-1:0] low;
      logic             fits;
      logic             neg;
      assign low = din[OUT_W-1:0];
      assign neg = SIGNED_DATA ? din[IN_W-1] : 1'b0;

      if (SIGNED_DATA) begin : g_sfit
         assign fits = (&din[IN_W-1:OUT_W-1]) | ~(|din[IN_W-1:OUT_W-1]);
      end else begin : g_ufit
         assign fits = ~(|din[IN_W-1:OUT_W]);
      end

      if (MODE == RSZ_WRAP) begin : g_wrap
         assign dout = low;
         assign ovf  = ~fits;
      end else if (!SIGNED_DATA) begin : g_uclip
         assign dout = fits ? low : UMAX;
         assign ovf  = ~fits;
      end else if (MODE == RSZ_CLIP) begin : g_sclip
         assign dout = fits ? low : (neg ? SMIN : SMAX);
         assign ovf  = ~fits;
      end else begin : g_ssym
         logic at_min;
         assign at_min = fits && (low == SMIN);
         always_comb begin
            if (!fits)       dout = neg ? SYM_MIN : SMAX;
            else if (at_min) dout = SYM_MIN;
            else             dout = low;
         end
         assign ovf = ~fits | at_min;
      end
   end
endmodule

// File: rtl/rsz_width_conv.sv
module rsz_width_conv
   import rsz_pkg::*;
#(
   parameter int        IN_W        = 5,
   parameter int        OUT_W       = 3,
   parameter bit        SIGNED_DATA = 1'b1,
   parameter rsz_mode_e MODE        = RSZ_CLIP_SYM,
   parameter int        PIPE_IN     = 0,
   parameter int        PIPE_OUT    = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IN_W-1:0]  in_data,
   input  logic             in_vld,
   output logic [OUT_W-1:0] out_data,
   output logic             out_ovf,
   output logic             out_vld
);
   localparam int IN_BUS_W  = IN_W + 1;
   localparam int OUT_BUS_W = OUT_W + 2;

   if (IN_W < 1)                  begin : g_chk_in   $error("IN_W must be >= 1");             end
   if (OUT_W < 2)                 begin : g_chk_out  $error("OUT_W must be >= 2");            end
   if (PIPE_IN < 0 || PIPE_OUT < 0) begin : g_chk_pipe $error("pipeline depths must be >= 0"); end

   logic [IN_BUS_W-1:0]  in_bus, mid_bus;
   logic [OUT_BUS_W-1:0] cv_bus, out_bus;
   logic [OUT_W-1:0]     cv_data;
   logic                 cv_ovf;

   assign in_bus = {in_vld, in_data};

   rsz_pipe #(.W(IN_BUS_W), .DEPTH(PIPE_IN)) u_pipe_in (
      .clk(clk), .rst_n(rst_n), .d(in_bus), .q(mid_bus)
   );

   rsz_narrow #(.IN_W(IN_W), .OUT_W(OUT_W), .SIGNED_DATA(SIGNED_DATA), .MODE(MODE)) u_narrow (
      .din(mid_bus[IN_W-1:0]), .dout(cv_data), .ovf(cv_ovf)
   );

   assign cv_bus = {mid_bus[IN_W], cv_ovf, cv_data};

   rsz_pipe #(.W(OUT_BUS_W), .DEPTH(PIPE_OUT)) u_pipe_out (
      .clk(clk), .rst_n(rst_n), .d(cv_bus), .q(out_bus)
   );

   assign out_vld  = out_bus[OUT_W+1];
   assign out_ovf  = out_bus[OUT_W];
   assign out_data = out_bus[OUT_W-1:0];
endmodule

// File: rtl/rsz_width_conv_chk.sv
module rsz_width_conv_chk
   import rsz_pkg::*;
#(
   parameter int        IN_W        = 5,
   parameter int        OUT_W       = 3,
   parameter bit        SIGNED_DATA = 1'b1,
   parameter rsz_mode_e MODE        = RSZ_CLIP_SYM
) (
   input logic             clk,
   input logic             rst_n,
   input logic [OUT_W-1:0] out_data,
   input logic             out_ovf,
   input logic             out_vld
);
   localparam logic [OUT_W-1:0] SMIN = {1'b1, {(OUT_W-1){1'b0}}};
   localparam logic [OUT_W-1:0] SMAX = ~SMIN;
   localparam logic [OUT_W-1:0] SYM_MIN = SMIN + OUT_W'(1);
   localparam logic [OUT_W-1:0] UMAX = '1;

   // R8
   reset_zero_chk: assert property (@(posedge clk)
      !rst_n |-> (out_vld == 1'b0 && out_ovf == 1'b0 && out_data == '0));

   if (OUT_W >= IN_W) begin : g_ext
      // R1
      no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         out_vld |-> !out_ovf);
   end else if (SIGNED_DATA && MODE == RSZ_CLIP_SYM) begin : g_sym
      // R5
      sym_no_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
         out_vld |-> out_data != SMIN);
      // R5
      sym_ovf_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (out_vld && out_ovf) |-> (out_data == SMAX || out_data == SYM_MIN));
   end else if (SIGNED_DATA && MODE == RSZ_CLIP) begin : g_sclip
      // R4
      sclip_ovf_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (out_vld && out_ovf) |-> (out_data == SMAX || out_data == SMIN));
   end else if (!SIGNED_DATA && MODE != RSZ_WRAP) begin : g_uclip
      // R3
      uclip_ovf_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (out_vld && out_ovf) |-> out_data == UMAX);
   end
endmodule

bind rsz_width_conv rsz_width_conv_chk #(
   .IN_W(IN_W), .OUT_W(OUT_W), .SIGNED_DATA(SIGNED_DATA), .MODE(MODE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .out_data(out_data), .out_ovf(out_ovf), .out_vld(out_vld)
);

// File: tb/sim_rsz_width_conv.sv
`timescale 1ns/1ps
module sim_rsz_width_conv;
   import rsz_pkg::*;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [4:0] x = '0;
   logic       v = 1'b0;
   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   logic [2:0] d0, d1, d2, d3, d4;
   logic [4:0] d5, d6, d7;
   logic [7:0] o, vv;

   rsz_width_conv u0 (.clk(clk), .rst_n(rst_n), .in_data(x), .in_vld(v),
      .out_data(d0), .out_ovf(o[0]), .out_vld(vv[0]));
   rsz_width_conv #(.IN_W(5), .OUT_W(3), .SIGNED_DATA(1), .MODE(RSZ_WRAP)) u1 (.clk(clk), .rst_n(rst_n),
      .in_data(x), .in_vld(v), .out_data(d1), .out_ovf(o[1]), .out_vld(vv[1]));
   rsz_width_conv #(.IN_W(5), .OUT_W(3), .SIGNED_DATA(1), .MODE(RSZ_CLIP)) u2 (.clk(clk), .rst_n(rst_n),
      .in_data(x), .in_vld(v), .out_data(d2), .out_ovf(o[2]), .out_vld(vv[2]));
   rsz_width_conv #(.IN_W(5), .OUT_W(3), .SIGNED_DATA(0), .MODE(RSZ_WRAP)) u3 (.clk(clk), .rst_n(rst_n),
      .in_data(x), .in_vld(v), .out_data(d3), .out_ovf(o[3]), .out_vld(vv[3]));
   rsz_width_conv #(.IN_W(5), .OUT_W(3), .SIGNED_DATA(0), .MODE(RSZ_CLIP), .PIPE_IN(1), .PIPE_OUT(1)) u4 (
      .clk(clk), .rst_n(rst_n), .in_data(x), .in_vld(v), .out_data(d4), .out_ovf(o[4]), .out_vld(vv[4]));
   rsz_width_conv #(.IN_W(3), .OUT_W(5), .SIGNED_DATA(1), .MODE(RSZ_CLIP_SYM)) u5 (.clk(clk), .rst_n(rst_n),
      .in_data(x[2:0]), .in_vld(v), .out_data(d5), .out_ovf(o[5]), .out_vld(vv[5]));
   rsz_width_conv #(.IN_W(3), .OUT_W(5), .SIGNED_DATA(0), .MODE(RSZ_CLIP)) u6 (.clk(clk), .rst_n(rst_n),
      .in_data(x[2:0]), .in_vld(v), .out_data(d6), .out_ovf(o[6]), .out_vld(vv[6]));
   rsz_width_conv #(.IN_W(5), .OUT_W(5), .SIGNED_DATA(1), .MODE(RSZ_CLIP)) u7 (.clk(clk), .rst_n(rst_n),
      .in_data(x), .in_vld(v), .out_data(d7), .out_ovf(o[7]), .out_vld(vv[7]));

   // Reference model: returns (ovf << 16) | output code
   function automatic int model(int code, int iw, int ow, bit sgn, int mode);
      int c, val, lo, hi, res, ov;
      c   = code & ((1 << iw) - 1);
      val = (sgn && c >= (1 << (iw-1))) ? c - (1 << iw) : c;
      ov  = 0;
      if (ow >= iw) begin
         res = val;
      end else begin
         lo = sgn ? -(1 << (ow-1)) : 0;
         hi = sgn ? (1 << (ow-1)) - 1 : (1 << ow) - 1;
         if (val < lo || val > hi) ov = 1;
         if (mode == 0)             res = val;
         else if (val > hi)         res = hi;
         else if (val < lo)         res = (sgn && mode == 2) ? lo + 1 : lo;
         else                       res = val;
         if (sgn && mode == 2 && res == lo) begin res = lo + 1; ov = 1; end
      end
      return (ov << 16) | (res & ((1 << ow) - 1));
   endfunction

   task automatic chk(string what, int got, int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", what, got, exp);
      end
   endtask

   task automatic chk_inst(string nm, string req, int got_d, logic got_o, logic got_v,
                           int code, logic vin, int iw, int ow, bit sgn, int mode);
      int e;
      chk({nm, " R7 valid"}, int'(got_v), int'(vin));
      if (vin) begin
         e = model(code, iw, ow, sgn, mode);
         chk({nm, " ", req, " data"}, got_d, e & 16'hFFFF);
         chk({nm, " R6 ovf"}, int'(got_o), e >> 16);
      end
   endtask

   int h1 = 0, h2 = 0;
   logic v1 = 1'b0, v2 = 1'b0;

   task automatic step(logic [4:0] nx, logic nv);
      @(negedge clk);
      chk_inst("u0", "R5", int'(d0), o[0], vv[0], h1, v1, 5, 3, 1, 2);
      chk_inst("u1", "R2", int'(d1), o[1], vv[1], h1, v1, 5, 3, 1, 0);
      chk_inst("u2", "R4", int'(d2), o[2], vv[2], h1, v1, 5, 3, 1, 1);
      chk_inst("u3", "R2", int'(d3), o[3], vv[3], h1, v1, 5, 3, 0, 0);
      chk_inst("u4", "R3", int'(d4), o[4], vv[4], h2, v2, 5, 3, 0, 1);
      chk_inst("u5", "R1", int'(d5), o[5], vv[5], h1, v1, 3, 5, 1, 2);
      chk_inst("u6", "R1", int'(d6), o[6], vv[6], h1, v1, 3, 5, 0, 1);
      chk_inst("u7", "R1", int'(d7), o[7], vv[7], h1, v1, 5, 5, 1, 1);
      h2 = h1; v2 = v1;
      h1 = int'(nx); v1 = nv;
      x = nx; v = nv;
   endtask

   initial begin
      int seed;
      seed = 32'd20211;
      void'($urandom(seed));
      x = 5'd17; v = 1'b1;               // activity while in reset
      repeat (3) @(negedge clk);
      // R8: everything held at zero during reset
      chk("R8 data u0", int'(d0), 0);
      chk("R8 ovf", int'(o), 0);
      chk("R8 valid", int'(vv), 0);
      chk("R8 data u5", int'(d5), 0);
      x = '0; v = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      // directed corners: most negative narrowed code, limits
      step(5'b11100, 1'b1);              // -4 : R5 becomes -3 with ovf
      step(5'b00011, 1'b1);              // +3 fits
      step(5'b00100, 1'b1);              // +4 out of range
      step(5'b10000, 1'b1);              // -16
      step(5'b01111, 1'b1);              // +15
      // full sweep of every code, back to back
      for (int i = 0; i < 32; i++) step(5'(i), 1'b1);
      // sweep with gaps in valid
      for (int i = 0; i < 32; i++) begin
         step(5'(i), 1'b1);
         step(5'($urandom), 1'b0);
      end
      // random mix
      for (int i = 0; i < 3000; i++) step(5'($urandom), 1'($urandom_range(0, 3) != 0));
      step('0, 1'b0);
      step('0, 1'b0);
      step('0, 1'b0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
         $finish;
      end
   end
endmodule